// File: doc/BRIEF.md
# Superframe Slot Time-Base Controller

This block keeps the repeating superframe clock of a distributed wireless MAC. A prescaler turns the system clock into a one-microsecond tick. Ticks are counted into fixed-length media access slots, and slots are counted into a superframe whose slot index wraps back to zero. At the default parameters that is 256 slots of 256 microseconds each, for 65,536 microseconds per superframe. Each slot carries one of four allocation codes: contention, beacon, reservation owned by this device, or reservation held by another device. The block always presents the index and code of the current slot.

Software writes the per-slot allocation schedule one slot at a time into a shadow copy. The shadow copy becomes the working schedule only at the next superframe start, so the schedule never changes part way through a superframe. From the working schedule the block reports how many microseconds remain before the current run of identically typed slots ends. The transmit path asks whether a frame exchange of a given length and access kind may start. The block grants the request only if the kind matches the current slot and the exchange ends before the allocation boundary.

Top module: `sf_slot_ctrl`

## Requirements
- R1: After reset the slot index is 0, the slot type is contention (code 0), the window output equals NUM_SLOTS*SLOT_US, and the start pulse and response valid are low. The working schedule is reset to contention in every slot.
- R2: Every PRESCALE clock cycles are one microsecond. The slot index advances by one every SLOT_US microseconds and wraps from NUM_SLOTS-1 to 0.
- R3: The start-of-superframe output is high for exactly one cycle, the cycle in which the slot index has just wrapped to 0.
- R4: A schedule write (slot number and 2-bit code) changes only the shadow copy. It changes the reported slot type only from the next superframe start onward. A write accepted on the clock edge where the index wraps is already included in the new superframe.
- R5: The slot type output is the 2-bit code of the working schedule entry for the current slot: 0 contention, 1 beacon, 2 owned reservation, 3 reservation held by another device.
- R6: The window output is (L*SLOT_US - u). L counts the slots from the current one up to the first slot of a different code, or up to the end of the superframe, without wrapping. u is the number of whole microseconds already elapsed in the current slot.
- R7: A request of kind K (0 contention, 1 beacon, 2 owned reservation) and duration D microseconds is granted only when K equals the current slot code and D is no more than the window output.
- R8: Slots of code 3 deny every request, and request kind 3 is always denied.
- R9: A response appears on the cycle after each cycle with a request present, and only then. The grant is evaluated on the state of the cycle in which the request was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en_i | input | 1 | Schedule write strobe |
| map_wr_slot_i | input | SLOT_W | Slot number being written |
| map_wr_type_i | input | 2 | Allocation code for that slot |
| req_valid_i | input | 1 | Access request present |
| req_kind_i | input | 2 | Access kind requested |
| req_dur_i | input | REM_W | Required exchange duration in microseconds |
| sf_start_o | output | 1 | One-cycle start-of-superframe pulse |
| slot_idx_o | output | SLOT_W | Current slot index |
| slot_type_o | output | 2 | Current slot allocation code |
| window_us_o | output | REM_W | Microseconds left in the current same-code run |
| resp_valid_o | output | 1 | Response to last cycle's request |
| resp_grant_o | output | 1 | Request granted |

## Verification
Assertions check on every cycle several properties. The slot index only steps by one or wraps, and only at the last microsecond of a slot. The start pulse coincides with slot 0 microsecond 0 after the last slot. The working schedule holds still except at a wrap. Every grant had a matching kind, a non-foreign slot and a duration within the window. The window never leaves its legal range. Only the bench scenarios can show behaviour that needs a reference schedule. Those scenarios cover the exact window value across runs of mixed codes, the one-superframe delay of schedule writes including a write on the wrap edge, and the grant decision exactly at and one microsecond past the boundary.

// File: rtl/sfslot_pkg.sv
package sfslot_pkg;

    // Allocation codes; request kinds 0..2 share these values.
    localparam logic [1:0] CODE_CONT    = 2'd0;
    localparam logic [1:0] CODE_BEACON  = 2'd1;
    localparam logic [1:0] CODE_OWNED   = 2'd2;
    localparam logic [1:0] CODE_FOREIGN = 2'd3;

    function automatic logic kind_allowed(input logic [1:0] slot_code,
                                          input logic [1:0] req_kind);
        return (req_kind != CODE_FOREIGN) && (req_kind == slot_code);
    endfunction

    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/sf_tick_timer.sv
module sf_tick_timer #(
    parameter int PRESCALE  = 64,
    parameter int SLOT_US   = 256,
    parameter int NUM_SLOTS = 256,
    localparam int PS_W   = sfslot_pkg::width_of(PRESCALE),
    localparam int US_W   = sfslot_pkg::width_of(SLOT_US),
    localparam int SLOT_W = sfslot_pkg::width_of(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [US_W-1:0]   us_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              wrap_o,
    output logic              sf_start_o
);

    typedef struct packed {
        logic [PS_W-1:0]   ps;
        logic [US_W-1:0]   us;
        logic [SLOT_W-1:0] slot;
        logic              sf;
    } tmr_t;

    tmr_t q, d;
    logic tick, last_us, last_slot;

    always_comb begin
        d         = q;
        d.sf      = 1'b0;
        tick      = (q.ps == PS_W'(PRESCALE - 1));
        last_us   = (q.us == US_W'(SLOT_US - 1));
        last_slot = (q.slot == SLOT_W'(NUM_SLOTS - 1));
        wrap_o    = tick && last_us && last_slot;
        if (tick) begin
            d.ps = '0;
            if (last_us) begin
                d.us = '0;
                if (last_slot) begin
                    d.slot = '0;
                    d.sf   = 1'b1;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end else begin
                d.us = q.us + 1'b1;
            end
        end else begin
            d.ps = q.ps + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign us_o       = q.us;
    assign slot_o     = q.slot;
    assign sf_start_o = q.sf;

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.slot != $past(q.slot)) |-> ((q.slot == SLOT_W'($past(q.slot) + 1'b1)) ||
            (q.slot == '0 && $past(q.slot) == SLOT_W'(NUM_SLOTS - 1)))); // R2
    AST_SLOT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.slot != $past(q.slot)) |-> ($past(q.us) == US_W'(SLOT_US - 1))); // R2
    AST_SF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.sf |-> (q.slot == '0 && q.us == '0 && $past(q.slot) == SLOT_W'(NUM_SLOTS - 1))); // R3

endmodule

// File: rtl/sf_alloc_map.sv
module sf_alloc_map #(
    parameter int NUM_SLOTS = 256,
    localparam int SLOT_W = sfslot_pkg::width_of(NUM_SLOTS),
    localparam int RUN_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [1:0]        wr_type_i,
    input  logic              swap_i,
    input  logic [SLOT_W-1:0] cur_slot_i,
    output logic [1:0]        cur_type_o,
    output logic [RUN_W-1:0]  run_slots_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][1:0] shadow;
        logic [NUM_SLOTS-1:0][1:0] active;
    } map_t;

    map_t q, d;
    logic [RUN_W-1:0] run [NUM_SLOTS];

    always_comb begin
        d = q;
        if (wr_en_i) d.shadow[wr_slot_i] = wr_type_i;
        if (swap_i)  d.active = d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Suffix run lengths: slots from i onward sharing slot i's code.
    always_comb begin
        run[NUM_SLOTS-1] = RUN_W'(1);
        for (int i = NUM_SLOTS - 2; i >= 0; i--) begin
            run[i] = (q.active[i] == q.active[i+1]) ? run[i+1] + 1'b1 : RUN_W'(1);
        end
    end

    assign cur_type_o  = q.active[cur_slot_i];
    assign run_slots_o = run[cur_slot_i];

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> $stable(q.active)); // R4

endmodule

// File: rtl/sf_access_gate.sv
module sf_access_gate #(
    parameter int SLOT_US   = 256,
    parameter int NUM_SLOTS = 256,
    localparam int US_W  = sfslot_pkg::width_of(SLOT_US),
    localparam int RUN_W = $clog2(NUM_SLOTS + 1),
    localparam int TOTAL = NUM_SLOTS * SLOT_US,
    localparam int REM_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cur_type_i,
    input  logic [RUN_W-1:0] run_slots_i,
    input  logic [US_W-1:0]  us_i,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic [REM_W-1:0] req_dur_i,
    output logic [REM_W-1:0] remaining_o,
    output logic             resp_valid_o,
    output logic             resp_grant_o
);

    typedef struct packed {
        logic vld;
        logic gnt;
    } rsp_t;

    rsp_t q, d;
    logic [REM_W-1:0] remaining;

    always_comb begin
        remaining = REM_W'(run_slots_i) * REM_W'(SLOT_US) - REM_W'(us_i);
        d.vld     = req_valid_i;
        d.gnt     = req_valid_i && sfslot_pkg::kind_allowed(cur_type_i, req_kind_i)
                    && (req_dur_i <= remaining);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign remaining_o  = remaining;
    assign resp_valid_o = q.vld;
    assign resp_grant_o = q.gnt;

    AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        q.gnt |-> ($past(req_dur_i) <= $past(remaining))); // R7
    AST_GRANT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        q.gnt |-> ($past(req_kind_i) == $past(cur_type_i) && $past(cur_type_i) != 2'd3)); // R8
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld || q.gnt) |-> $past(req_valid_i)); // R9
    AST_WINDOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining != '0) && (remaining <= REM_W'(TOTAL))); // R6

endmodule

// File: rtl/sf_slot_ctrl.sv
module sf_slot_ctrl #(
    parameter int PRESCALE  = 64,
    parameter int SLOT_US   = 256,
    parameter int NUM_SLOTS = 256,
    localparam int SLOT_W = sfslot_pkg::width_of(NUM_SLOTS),
    localparam int US_W   = sfslot_pkg::width_of(SLOT_US),
    localparam int RUN_W  = $clog2(NUM_SLOTS + 1),
    localparam int REM_W  = $clog2(NUM_SLOTS * SLOT_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_wr_en_i,
    input  logic [SLOT_W-1:0] map_wr_slot_i,
    input  logic [1:0]        map_wr_type_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [REM_W-1:0]  req_dur_i,
    output logic              sf_start_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic [1:0]        slot_type_o,
    output logic [REM_W-1:0]  window_us_o,
    output logic              resp_valid_o,
    output logic              resp_grant_o
);

    logic [US_W-1:0]   us;
    logic [SLOT_W-1:0] slot;
    logic              wrap;
    logic [1:0]        cur_type;
    logic [RUN_W-1:0]  run_slots;

    sf_tick_timer #(.PRESCALE(PRESCALE), .SLOT_US(SLOT_US), .NUM_SLOTS(NUM_SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .us_o(us), .slot_o(slot),
        .wrap_o(wrap), .sf_start_o(sf_start_o)
    );

    sf_alloc_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(map_wr_en_i), .wr_slot_i(map_wr_slot_i), .wr_type_i(map_wr_type_i),
        .swap_i(wrap), .cur_slot_i(slot),
        .cur_type_o(cur_type), .run_slots_o(run_slots)
    );

    sf_access_gate #(.SLOT_US(SLOT_US), .NUM_SLOTS(NUM_SLOTS)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .cur_type_i(cur_type), .run_slots_i(run_slots), .us_i(us),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_dur_i(req_dur_i),
        .remaining_o(window_us_o), .resp_valid_o(resp_valid_o), .resp_grant_o(resp_grant_o)
    );

    assign slot_idx_o  = slot;
    assign slot_type_o = cur_type;

endmodule

// File: tb/tb_sf_slot_ctrl.sv
module tb_sf_slot_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PS = 2;
    localparam int SU = 8;
    localparam int NS = 16;
    localparam int SW = 4;
    localparam int RW = 8;
    localparam int SF_CYC = PS * SU * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [SW-1:0] wr_slot = '0;
    logic [1:0] wr_type = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [RW-1:0] req_dur = '0;
    logic sf_start, resp_valid, resp_grant;
    logic [SW-1:0] slot_idx;
    logic [1:0] slot_type;
    logic [RW-1:0] window_us;

    int n_chk = 0;
    int n_bad = 0;
    int ncyc = 0;
    logic req_seen = 1'b0;
    logic mon_on = 1'b0;
    logic done = 1'b0;
    logic [1:0] shad_m [NS];
    logic [1:0] act_m [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sf_slot_ctrl #(.PRESCALE(PS), .SLOT_US(SU), .NUM_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n),
        .map_wr_en_i(wr_en), .map_wr_slot_i(wr_slot), .map_wr_type_i(wr_type),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_dur_i(req_dur),
        .sf_start_o(sf_start), .slot_idx_o(slot_idx), .slot_type_o(slot_type),
        .window_us_o(window_us), .resp_valid_o(resp_valid), .resp_grant_o(resp_grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, ncyc);
        end
    endtask

    function automatic int e_tot();
        return (ncyc / PS) % (NS * SU);
    endfunction
    function automatic int e_slot();
        return e_tot() / SU;
    endfunction
    function automatic int e_win();
        int s = e_slot();
        int r = 1;
        while ((s + r < NS) && (act_m[s + r] == act_m[s])) r++;
        return r * SU - (e_tot() % SU);
    endfunction
    function automatic int e_grant(input int kind, input int dur);
        return (kind != 3 && kind == int'(act_m[e_slot()]) && dur <= e_win()) ? 1 : 0;
    endfunction

    // Bench-side time model, advanced on the same edges as the design.
    always @(posedge clk) begin
        if (!rst_n) ncyc = 0;
        else begin
            ncyc = ncyc + 1;
            if (ncyc % SF_CYC == 0) for (int i = 0; i < NS; i++) act_m[i] = shad_m[i];
        end
        req_seen = req_valid;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R2 slot index", slot_idx, e_slot());
            chk("R5 slot type", slot_type, act_m[e_slot()]);
            chk("R6 window", window_us, e_win());
            chk("R3 start pulse", sf_start, (ncyc > 0 && ncyc % SF_CYC == 0) ? 1 : 0);
            chk("R9 response valid", resp_valid, req_seen);
        end
    end

    task automatic map_write(input int s, input int code);
        wr_en = 1'b1; wr_slot = SW'(s); wr_type = 2'(code);
        shad_m[s] = 2'(code);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input string tag, input int kind, input int dur);
        int exp = e_grant(kind, dur);
        req_valid = 1'b1; req_kind = 2'(kind); req_dur = RW'(dur);
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, resp_grant, exp);
    endtask

    task automatic goto_cycle(input int target);
        while (ncyc < target) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin shad_m[i] = 2'd0; act_m[i] = 2'd0; end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, before the first active edge
        chk("R1 slot", slot_idx, 0);
        chk("R1 type", slot_type, 0);
        chk("R1 window", window_us, NS * SU);
        chk("R1 start", sf_start, 0);
        chk("R1 resp", resp_valid, 0);
        mon_on = 1'b1;

        // Schedule: 0-1 beacon, 2-5 owned, 6 foreign, 7-10 contention, 11-15 owned.
        goto_cycle(40);
        for (int s = 0; s < NS; s++)
            map_write(s, (s < 2) ? 1 : (s < 6) ? 2 : (s == 6) ? 3 : (s < 11) ? 0 : 2);
        // R4: still contention in this superframe
        @(negedge clk);
        chk("R4 old schedule kept", slot_type, 0);
        request("R4 contention still allowed", 0, 1);

        // Second superframe: directed grants.
        goto_cycle(SF_CYC + 2 * SU * PS);            // start of slot 2 (owned run 2..5)
        chk("R6 window at run start", window_us, 4 * SU);
        request("R7 dur equals window", 2, e_win());
        request("R7 dur one past window", 2, e_win() + 1);
        request("R7 wrong kind", 0, 1);
        goto_cycle(SF_CYC + 6 * SU * PS + 3);          // foreign slot
        request("R8 foreign slot owned kind", 2, 1);
        request("R8 foreign slot contention", 0, 0);
        goto_cycle(SF_CYC + 12 * SU * PS + 5);         // owned run to end, no wrap
        request("R6 run ends at superframe edge", 2, e_win());
        request("R8 kind three", 3, 0);
        goto_cycle(SF_CYC + 1);
        // (already passed) keep ordering monotonic

        // R4: write on the wrap edge itself.
        goto_cycle(2 * SF_CYC - 1);
        map_write(0, 0);
        chk("R4 write on wrap edge applied", slot_type, 0);
        request("R5 contention at slot 0", 0, SU);

        // Random phase.
        for (int k = 0; k < 400; k++) begin
            int gap = $urandom_range(0, 6);
            repeat (gap) @(negedge clk);
            if ($urandom_range(0, 3) == 0)
                map_write($urandom_range(0, NS - 1), $urandom_range(0, 3));
            else if ($urandom_range(0, 1) == 0)
                request("R7 random request", $urandom_range(0, 3), e_win() - 1 + $urandom_range(0, 2));
            else
                request("R7 random request", $urandom_range(0, 3), $urandom_range(0, NS * SU));
        end
        repeat (SF_CYC) @(negedge clk);

        done = 1'b1;
        mon_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule